// File: doc/BRIEF.md
# Dual-Bank Byte-Lane Access Splitter

This block sits between a requester that thinks in bytes and a 16-bit memory built from two byte-wide banks: an even bank on data lanes 7:0 and an odd bank on lanes 15:8. Each request names a 20-bit byte address, a size (byte or word), a direction and, for writes, 16 bits of data. The block turns the request into one or two bank transfers. For each transfer it drives a 19-bit bank address, a low-bank select bit and an active-low high-bank enable. It also places write bytes on the correct lanes.

Aligned words and single bytes need one transfer. A word at an odd address straddles a bank-address boundary, so the block issues two single-byte transfers in sequence and swaps lanes for each one. Read bytes are gathered into a right-justified 16-bit result. Bus timing is left to a downstream sequencer. The sequencer takes each transfer over a valid/done handshake: the descriptor stays steady while valid is high, and one cycle of done closes the transfer.

Top module: `byte_lane_splitter`

## Requirements
- R1: A word read returns the byte at the request address in result bits 7:0 and the byte at address+1 in bits 15:8.
- R2: A transfer drives bank address = byte address bits 19:1. A low-bank select of 0 enables lanes 7:0, a high-bank enable of 0 enables lanes 15:8, and at least one bank is always enabled during a transfer.
- R3: A byte at an even address is one transfer with select 0 and high enable 1. A write puts data bits 7:0 on lanes 7:0 with lanes 15:8 at zero. A read returns lanes 7:0 zero-extended.
- R4: A byte at an odd address is one transfer with select 1 and high enable 0. A write puts data bits 7:0 on lanes 15:8 with lanes 7:0 at zero. A read returns lanes 15:8 in result bits 7:0, with bits 15:8 zero.
- R5: A word at an even address is one transfer with select 0 and high enable 0. Write data passes straight through, and read lanes pass straight to the result.
- R6: A word at an odd address is two transfers. The first has select 1 and high enable 0, carries data bits 7:0 on lanes 15:8, and captures read lanes 15:8 into result bits 7:0. The second has select 0 and high enable 1, carries data bits 15:8 on lanes 7:0 (upper lanes zero), and captures read lanes 7:0 into result bits 15:8.
- R7: The second transfer of a split word uses bank address (address+1) bits 19:1, with a carry into every higher bit (01FFFh goes to bank address 01000h).
- R8: A split word at FFFFFh wraps its second byte to byte address 00000h (bank address 0).
- R9: A request is accepted only when req_ready is 1, and req_ready is 1 exactly when no request is in progress. A request presented while busy causes no transfer and does not change the one in progress.
- R10: done is a one-cycle pulse in the cycle after bus_done of the last transfer, with rdata valid in that cycle. rdata is zero for writes.
- R11: While bus_valid is 1 and bus_done is 0, the descriptor (bank address, select, high enable, direction, write lanes) holds steady. On reads, bus_wdata is zero.
- R12: After reset, bus_valid and done are 0 and req_ready is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block idle; a request is taken this cycle |
| req_addr | input | 20 | Byte address |
| req_word | input | 1 | 1 = 16-bit word, 0 = byte |
| req_write | input | 1 | 1 = write, 0 = read |
| req_wdata | input | 16 | Write data, right-justified for bytes |
| bus_valid | output | 1 | Transfer descriptor valid |
| bus_bank_addr | output | 19 | Address shared by both banks |
| bus_a0 | output | 1 | Low-bank select, active low |
| bus_bhe_n | output | 1 | High-bank enable, active low |
| bus_write | output | 1 | Transfer direction |
| bus_wdata | output | 16 | Lane-steered write data |
| bus_done | input | 1 | Sequencer finished the current transfer |
| bus_rdata | input | 16 | Read lanes from the banks |
| done | output | 1 | Request complete pulse |
| rdata | output | 16 | Assembled, right-justified read result |

## Verification
The bench builds the block with its default parameters: a 20-bit byte address and 8-bit lanes. At this size the address can be driven to its very top, so the FFFFFh wrap and the 01FFFh-to-02000h carry are exercised directly. A behavioural memory answers each transfer after a varying number of wait states, which exercises descriptor hold under stall. A request held high throughout a busy split word shows that busy requests are ignored.

// File: rtl/bls_pkg.sv
package bls_pkg;
    typedef enum logic [1:0] {
        PH_IDLE   = 2'd0,
        PH_FIRST  = 2'd1,
        PH_SECOND = 2'd2
    } phase_e;
endpackage

// File: rtl/split_plan.sv
module split_plan #(
    parameter int ADDR_W = 20
) (
    input  logic [ADDR_W-1:0] base_addr,
    input  logic              is_word,
    input  logic              second,
    output logic [ADDR_W-2:0] bank_addr,
    output logic              a0,
    output logic              bhe_n,
    output logic              needs_split
);
    logic [ADDR_W-1:0] cur_addr;

    always_comb begin
        cur_addr    = second ? base_addr + ADDR_W'(1) : base_addr;
        bank_addr   = cur_addr[ADDR_W-1:1];
        a0          = cur_addr[0];
        needs_split = is_word & base_addr[0];
        if (second) begin
            bhe_n = 1'b1;
        end else begin
            bhe_n = ~(is_word | base_addr[0]);
        end
    end
endmodule

// File: rtl/lane_steer.sv
module lane_steer #(
    parameter int BYTE_W = 8,
    localparam int DW    = 2 * BYTE_W
) (
    input  logic          lo_en,
    input  logic          hi_en,
    input  logic          second,
    input  logic          is_write,
    input  logic [DW-1:0] req_wdata,
    input  logic [DW-1:0] bus_rdata,
    input  logic [DW-1:0] rdata_acc,
    output logic [DW-1:0] bus_wdata,
    output logic [DW-1:0] rdata_next
);
    localparam logic [BYTE_W-1:0] ZB = '0;

    always_comb begin
        if (!is_write) begin
            bus_wdata = '0;
        end else if (second) begin
            bus_wdata = {ZB, req_wdata[DW-1:BYTE_W]};
        end else if (lo_en && hi_en) begin
            bus_wdata = req_wdata;
        end else if (hi_en) begin
            bus_wdata = {req_wdata[BYTE_W-1:0], ZB};
        end else begin
            bus_wdata = {ZB, req_wdata[BYTE_W-1:0]};
        end

        if (second) begin
            rdata_next = {bus_rdata[BYTE_W-1:0], rdata_acc[BYTE_W-1:0]};
        end else if (lo_en && hi_en) begin
            rdata_next = bus_rdata;
        end else if (hi_en) begin
            rdata_next = {ZB, bus_rdata[DW-1:BYTE_W]};
        end else begin
            rdata_next = {ZB, bus_rdata[BYTE_W-1:0]};
        end
    end
endmodule

// File: rtl/byte_lane_splitter.sv
module byte_lane_splitter
    import bls_pkg::*;
#(
    parameter int ADDR_W = 20,
    parameter int BYTE_W = 8,
    localparam int DW    = 2 * BYTE_W,
    localparam int BAW   = ADDR_W - 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic              req_word,
    input  logic              req_write,
    input  logic [DW-1:0]     req_wdata,
    output logic              bus_valid,
    output logic [BAW-1:0]    bus_bank_addr,
    output logic              bus_a0,
    output logic              bus_bhe_n,
    output logic              bus_write,
    output logic [DW-1:0]     bus_wdata,
    input  logic              bus_done,
    input  logic [DW-1:0]     bus_rdata,
    output logic              done,
    output logic [DW-1:0]     rdata
);
    typedef struct packed {
        phase_e            ph;
        logic [ADDR_W-1:0] addr;
        logic              word;
        logic              wr;
        logic [DW-1:0]     wdata;
        logic [DW-1:0]     rdata;
        logic              done;
    } st_t;

    st_t st_d, st_q;

    logic          second;
    logic          split;
    logic [DW-1:0] rd_next;

    assign second = (st_q.ph == PH_SECOND);

    split_plan #(.ADDR_W(ADDR_W)) i_plan (
        .base_addr  (st_q.addr),
        .is_word    (st_q.word),
        .second     (second),
        .bank_addr  (bus_bank_addr),
        .a0         (bus_a0),
        .bhe_n      (bus_bhe_n),
        .needs_split(split)
    );

    lane_steer #(.BYTE_W(BYTE_W)) i_steer (
        .lo_en     (~bus_a0),
        .hi_en     (~bus_bhe_n),
        .second    (second),
        .is_write  (st_q.wr),
        .req_wdata (st_q.wdata),
        .bus_rdata (bus_rdata),
        .rdata_acc (st_q.rdata),
        .bus_wdata (bus_wdata),
        .rdata_next(rd_next)
    );

    always_comb begin
        st_d      = st_q;
        st_d.done = 1'b0;
        case (st_q.ph)
            PH_IDLE: begin
                if (req_valid) begin
                    st_d.ph    = PH_FIRST;
                    st_d.addr  = req_addr;
                    st_d.word  = req_word;
                    st_d.wr    = req_write;
                    st_d.wdata = req_wdata;
                    st_d.rdata = '0;
                end
            end
            PH_FIRST: begin
                if (bus_done) begin
                    if (!st_q.wr) begin
                        st_d.rdata = rd_next;
                    end
                    if (split) begin
                        st_d.ph = PH_SECOND;
                    end else begin
                        st_d.ph   = PH_IDLE;
                        st_d.done = 1'b1;
                    end
                end
            end
            PH_SECOND: begin
                if (bus_done) begin
                    if (!st_q.wr) begin
                        st_d.rdata = rd_next;
                    end
                    st_d.ph   = PH_IDLE;
                    st_d.done = 1'b1;
                end
            end
            default: st_d.ph = PH_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign req_ready = (st_q.ph == PH_IDLE);
    assign bus_valid = (st_q.ph != PH_IDLE);
    assign bus_write = st_q.wr;
    assign done      = st_q.done;
    assign rdata     = st_q.rdata;

    // R2: some bank is always enabled during a transfer
    p_lane_sel_r2: assert property (@(posedge clk) disable iff (!rst_n)
        bus_valid |-> !(bus_a0 && bus_bhe_n));

    // R2 and R9: accepted request shows up as the first transfer address
    p_accept_addr_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=>
            (bus_valid && bus_bank_addr == $past(req_addr[ADDR_W-1:1])));

    // R11: descriptor holds while the sequencer stalls
    p_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_valid && !bus_done) |=>
            (bus_valid && $stable(bus_bank_addr) && $stable(bus_a0) &&
             $stable(bus_bhe_n) && $stable(bus_wdata) && $stable(bus_write)));

    // R11: no lane is driven on reads
    p_rd_quiet_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_valid && !bus_write) |-> (bus_wdata == '0));

    // R6: split word continues with the even byte only
    p_second_low_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.ph == PH_FIRST && bus_done && split) |=>
            (bus_valid && !bus_a0 && bus_bhe_n));

    // R7 and R8: second byte address is the first plus one, wrapping
    p_next_addr_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.ph == PH_FIRST && bus_done && split) |=>
            ({bus_bank_addr, bus_a0} ==
             ADDR_W'($past({bus_bank_addr, bus_a0}) + ADDR_W'(1))));

    // R10: done is a single-cycle pulse that follows a finished transfer
    p_done_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    p_done_cause_r10: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> ($past(bus_done) && $past(bus_valid)));
endmodule

// File: tb/test_byte_lane_splitter.sv
module test_byte_lane_splitter;
    localparam int AW = 20;
    localparam int DW = 16;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          req_valid = 1'b0;
    logic          req_ready;
    logic [AW-1:0] req_addr = '0;
    logic          req_word = 1'b0;
    logic          req_write = 1'b0;
    logic [DW-1:0] req_wdata = '0;
    logic          bus_valid;
    logic [AW-2:0] bus_bank_addr;
    logic          bus_a0;
    logic          bus_bhe_n;
    logic          bus_write;
    logic [DW-1:0] bus_wdata;
    logic          bus_done = 1'b0;
    logic [DW-1:0] bus_rdata = '0;
    logic          done;
    logic [DW-1:0] rdata;

    always #5 clk = ~clk;

    byte_lane_splitter i_byte_lane_splitter (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr),
        .req_word(req_word), .req_write(req_write), .req_wdata(req_wdata),
        .bus_valid(bus_valid), .bus_bank_addr(bus_bank_addr), .bus_a0(bus_a0),
        .bus_bhe_n(bus_bhe_n), .bus_write(bus_write), .bus_wdata(bus_wdata),
        .bus_done(bus_done), .bus_rdata(bus_rdata), .done(done), .rdata(rdata)
    );

    typedef struct {
        logic [AW-2:0] bank;
        logic          a0;
        logic          bhe_n;
        logic          wr;
        logic [DW-1:0] wdata;
        string         tag;
    } xfer_t;

    typedef struct {
        logic [DW-1:0] data;
        string         tag;
    } res_t;

    xfer_t xq[$];
    res_t  rq[$];
    int checks = 0;
    int failures = 0;
    int res_seen = 0;
    int xfer_cnt = 0;
    bit finished = 1'b0;

    function automatic logic [7:0] mb(logic [AW-1:0] x);
        return x[7:0] ^ {x[11:8], x[15:12]} ^ {4'h0, x[19:16]} ^ 8'h3C;
    endfunction

    task automatic chk(bit ok, string tag, string what, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    // bus-side monitor and memory model
    initial begin : bus_mon
        bit   active = 1'b0;
        int   waitc = 0;
        xfer_t e;
        forever begin
            @(negedge clk);
            if (bus_done) begin
                bus_done = 1'b0;
                active = 1'b0;
            end
            if (bus_valid && rst_n) begin
                if (!active) begin
                    active = 1'b1;
                    waitc = xfer_cnt % 3;
                    xfer_cnt++;
                    if (xq.size() == 0) begin
                        chk(1'b0, "R9", "unexpected transfer", {13'b0, bus_bank_addr}, 32'h0);
                        e.bank = bus_bank_addr; e.a0 = bus_a0; e.bhe_n = bus_bhe_n;
                        e.wr = bus_write; e.wdata = bus_wdata; e.tag = "R9";
                    end else begin
                        e = xq.pop_front();
                    end
                    chk(bus_bank_addr == e.bank, e.tag, "bank_addr", {13'b0, bus_bank_addr}, {13'b0, e.bank});
                    chk({bus_a0, bus_bhe_n} == {e.a0, e.bhe_n}, e.tag, "a0/bhe_n",
                        {30'b0, bus_a0, bus_bhe_n}, {30'b0, e.a0, e.bhe_n});
                    chk(bus_write == e.wr && bus_wdata == e.wdata, e.tag, "write lanes",
                        {15'b0, bus_write, bus_wdata}, {15'b0, e.wr, e.wdata});
                end
                if (waitc == 0) begin
                    chk(bus_bank_addr == e.bank && bus_wdata == e.wdata &&
                        {bus_a0, bus_bhe_n} == {e.a0, e.bhe_n}, "R11", "held descriptor",
                        {bus_bank_addr, bus_a0, bus_bhe_n, 11'b0}, {e.bank, e.a0, e.bhe_n, 11'b0});
                    bus_rdata = {mb({bus_bank_addr, 1'b1}), mb({bus_bank_addr, 1'b0})};
                    bus_done = 1'b1;
                end else begin
                    waitc--;
                end
            end
        end
    end

    // result monitor
    initial begin : res_mon
        res_t r;
        forever begin
            @(negedge clk);
            if (done && rst_n) begin
                res_seen++;
                if (rq.size() == 0) begin
                    chk(1'b0, "R10", "unexpected done", {16'b0, rdata}, 32'h0);
                end else begin
                    r = rq.pop_front();
                    chk(rdata == r.data, r.tag, "rdata", {16'b0, rdata}, {16'b0, r.data});
                end
            end
        end
    end

    // driver: pushes expected transfers and result, then issues the request
    task automatic issue(logic [AW-1:0] a, bit word, bit wr, logic [DW-1:0] wd, bit jam);
        xfer_t x;
        res_t  r;
        logic [AW-1:0] n;
        int target;
        n = a + AW'(1);
        x.wr = wr;
        if (!word && !a[0]) begin
            x.bank = a[AW-1:1]; x.a0 = 1'b0; x.bhe_n = 1'b1;
            x.wdata = wr ? {8'h00, wd[7:0]} : 16'h0; x.tag = "R3";
            xq.push_back(x);
            r.data = wr ? 16'h0 : {8'h00, mb(a)}; r.tag = wr ? "R10" : "R3";
        end else if (!word) begin
            x.bank = a[AW-1:1]; x.a0 = 1'b1; x.bhe_n = 1'b0;
            x.wdata = wr ? {wd[7:0], 8'h00} : 16'h0; x.tag = "R4";
            xq.push_back(x);
            r.data = wr ? 16'h0 : {8'h00, mb(a)}; r.tag = wr ? "R10" : "R4";
        end else if (!a[0]) begin
            x.bank = a[AW-1:1]; x.a0 = 1'b0; x.bhe_n = 1'b0;
            x.wdata = wr ? wd : 16'h0; x.tag = "R5";
            xq.push_back(x);
            r.data = wr ? 16'h0 : {mb(n), mb(a)}; r.tag = wr ? "R10" : "R5/R1";
        end else begin
            x.bank = a[AW-1:1]; x.a0 = 1'b1; x.bhe_n = 1'b0;
            x.wdata = wr ? {wd[7:0], 8'h00} : 16'h0; x.tag = "R6";
            xq.push_back(x);
            x.bank = n[AW-1:1]; x.a0 = 1'b0; x.bhe_n = 1'b1;
            x.wdata = wr ? {8'h00, wd[15:8]} : 16'h0;
            x.tag = (a == '1) ? "R8" : "R7";
            xq.push_back(x);
            r.data = wr ? 16'h0 : {mb(n), mb(a)}; r.tag = wr ? "R10" : "R6/R1";
        end
        rq.push_back(r);
        target = res_seen + 1;
        @(negedge clk);
        while (!req_ready) @(negedge clk);
        req_valid = 1'b1; req_addr = a; req_word = word; req_write = wr; req_wdata = wd;
        @(negedge clk);
        req_valid = 1'b0;
        while (res_seen < target) begin
            if (jam) begin
                req_valid = !req_ready;
                req_addr = 20'h0ABCD; req_word = 1'b1; req_write = 1'b1; req_wdata = 16'hDEAD;
            end
            @(negedge clk);
        end
        req_valid = 1'b0;
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        if (!finished) begin
            failures++;
            checks++;
            $display("FAIL watchdog expired actual=%0d expected=%0d", res_seen, 0);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin : main
        repeat (3) @(negedge clk);
        chk(bus_valid == 1'b0 && done == 1'b0 && req_ready == 1'b1, "R12", "reset outputs",
            {29'b0, bus_valid, done, req_ready}, 32'h1);
        rst_n = 1'b1;
        @(negedge clk);
        // reads
        issue(20'h00124, 1'b0, 1'b0, 16'h0, 1'b0);
        issue(20'h01233, 1'b0, 1'b0, 16'h0, 1'b0);
        issue(20'h02002, 1'b1, 1'b0, 16'h0, 1'b0);
        issue(20'h01233, 1'b1, 1'b0, 16'h0, 1'b0);
        issue(20'h01FFF, 1'b1, 1'b0, 16'h0, 1'b0);
        issue(20'hFFFFF, 1'b1, 1'b0, 16'h0, 1'b0);
        issue(20'hFFFFF, 1'b0, 1'b0, 16'h0, 1'b0);
        issue(20'h00000, 1'b1, 1'b0, 16'h0, 1'b0);
        // writes
        issue(20'h00124, 1'b0, 1'b1, 16'h12A7, 1'b0);
        issue(20'h01233, 1'b0, 1'b1, 16'h34B9, 1'b0);
        issue(20'h02002, 1'b1, 1'b1, 16'hBEEF, 1'b0);
        issue(20'h01FFF, 1'b1, 1'b1, 16'hC0DE, 1'b0);
        issue(20'hFFFFF, 1'b1, 1'b1, 16'h5A69, 1'b0);
        // R9: requests held high while busy must be ignored
        issue(20'h05555, 1'b1, 1'b0, 16'h0, 1'b1);
        issue(20'h07001, 1'b1, 1'b1, 16'h9876, 1'b1);
        repeat (6) @(negedge clk);
        chk(xq.size() == 0 && rq.size() == 0, "R9", "no extra or missing transfers",
            xq.size() + rq.size(), 32'h0);
        chk(req_ready == 1'b1 && bus_valid == 1'b0 && done == 1'b0, "R9", "idle after busy requests",
            {29'b0, req_ready, bus_valid, done}, 32'h4);
        chk(xfer_cnt == 22, "R6", "total transfer count", xfer_cnt, 32'd22);
        finished = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule